// File: doc/BRIEF.md
# Dirty-Line Scan-and-Clean Engine

This block sits beside a write-back data cache and carries out one step of a whole-cache clean per command. On a command strobe it picks the lowest-numbered line that is both valid and dirty and asks memory to write that line back. Once memory acknowledges, it pulses a clear for that line's dirty bit. It then reports, in bit 30 of a 32-bit result and on a separate condition flag, whether any valid dirty line is still present. Software re-issues the command until the flag reads 1, so the cleaning loop is driven from outside and each command takes a bounded time.

A mode bit sent with the command selects clean-and-invalidate. That mode works exactly like clean-only. The one difference is that, once the command finds no valid dirty line left, it sends an invalidate strobe to every line in a single cycle before it signals done. The line state arrays, data array and tag logic stay outside the block. The engine only reads the valid and dirty vectors and drives strobes back to them.

The controller is a state machine with six states. ST_IDLE accepts a command, and cmd_ready is high only in this state. ST_SCAN runs the priority encoder: a hit goes to ST_WB, and a miss goes to ST_INVAL in invalidate mode or to ST_DONE otherwise. ST_WB holds the writeback request and moves to ST_CHECK on acknowledge. ST_CHECK re-reads the array after the clear: if nothing is dirty and the mode is invalidate it goes to ST_INVAL, and in every other case to ST_DONE. ST_INVAL always goes to ST_DONE, and ST_DONE always returns to ST_IDLE.

Top module: `dcl_clean_engine`

## Requirements
- R1: After reset, cmd_ready is 1, and wb_req, done, inval, dirty_clr, result and flag_clean are all 0.
- R2: Each accepted command issues exactly one writeback when at least one line is both valid and dirty, and none otherwise.
- R3: The line written back is the lowest index i with line_valid[i] and line_dirty[i] both 1. A line that is dirty but not valid is never written back, cleared or counted.
- R4: wb_req holds a constant wb_idx until wb_ack. dirty_clr stays 0 while waiting, and in the wb_ack cycle it is one-hot, with bit wb_idx set.
- R5: When done pulses, result[30] is 1 if no valid dirty line remains after this command's clean and 0 otherwise. All other result bits are 0. The value holds until the next command reaches its verdict.
- R6: flag_clean equals result[30], so the command that cleans the last dirty line reports 1.
- R7: In invalidate mode (cmd_inv = 1 at accept), a command that leaves no valid dirty line drives inval to all ones for one cycle before done. Afterwards every line reads invalid, and dirty bits of lines that were invalid are left untouched.
- R8: inval stays 0 in clean-only mode, and also in invalidate mode while valid dirty lines remain.
- R9: cmd_ready is 0 from acceptance until the cycle after done. A cmd_valid pulse during that time is not accepted and starts no further command.
- R10: done is high for exactly one cycle, and cmd_ready is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_inv | input | 1 | Mode: 1 = clean and invalidate, 0 = clean only |
| cmd_ready | output | 1 | Engine idle, command will be accepted |
| line_valid | input | N_LINES | Per-line valid bits |
| line_dirty | input | N_LINES | Per-line dirty bits |
| wb_req | output | 1 | Writeback request to memory |
| wb_idx | output | IDX_W | Line index of the writeback |
| wb_ack | input | 1 | Memory accepts the writeback |
| dirty_clr | output | N_LINES | Per-line dirty-clear strobe |
| inval | output | N_LINES | Per-line invalidate strobe |
| done | output | 1 | Command finished, result valid |
| result | output | 32 | Status word, bit 30 = no dirty line left |
| flag_clean | output | 1 | Condition flag mirroring result[30] |

## Verification
Every dirty pattern of an eight-line cache is tried, combined with fully valid and with sparsely valid states, so that lowest-index selection and the exclusion of invalid dirty lines can be told apart from one another. Each pattern is cleaned with repeated commands until the flag reads clean. The bench predicts the next index and the verdict itself, which separates a verdict taken before the clear from one taken after it. Acknowledge latencies from zero to three cycles, together with both modes, separate a correctly held request and an invalidate gated on cleanliness from premature or missing strobes. A cmd_valid pulse sent while the engine is busy shows whether the stall works.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    localparam int RESULT_W   = 32;
    localparam int STATUS_POS = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WB,
        ST_CHECK,
        ST_INVAL,
        ST_DONE
    } dcl_state_e;

    // Result word: only the cleanliness bit is ever set.
    function automatic logic [RESULT_W-1:0] pack_status(input logic clean);
        logic [RESULT_W-1:0] w;
        w = '0;
        w[STATUS_POS] = clean;
        return w;
    endfunction

endpackage

// File: rtl/dcl_first_set.sv
// Lowest-index-first selector over a request vector.
module dcl_first_set #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] gnt;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign gnt[i]    = req[i] & ~seen[i];
    end

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/dcl_onehot.sv
// Index-to-strobe decoder, gated by an enable.
module dcl_onehot #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  vec
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign vec[i] = en && (idx == IW'(i));
    end
endmodule

// File: rtl/dcl_clean_engine.sv
module dcl_clean_engine
    import dcl_pkg::*;
#(
    parameter int N_LINES = 16,
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_inv,
    output logic                cmd_ready,
    input  logic [N_LINES-1:0]  line_valid,
    input  logic [N_LINES-1:0]  line_dirty,
    output logic                wb_req,
    output logic [IDX_W-1:0]    wb_idx,
    input  logic                wb_ack,
    output logic [N_LINES-1:0]  dirty_clr,
    output logic [N_LINES-1:0]  inval,
    output logic                done,
    output logic [RESULT_W-1:0] result,
    output logic                flag_clean
);
    dcl_state_e       state_q, state_d;
    logic             mode_q, mode_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             clean_q, clean_d;

    logic [N_LINES-1:0] live;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic               clr_en;
    logic               inv_en;

    assign live = line_valid & line_dirty;

    dcl_first_set #(.N(N_LINES)) u_sel (
        .req   (live),
        .found (hit),
        .idx   (hit_idx)
    );

    dcl_onehot #(.N(N_LINES)) u_clr (
        .en  (clr_en),
        .idx (idx_q),
        .vec (dirty_clr)
    );

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            idx_q   <= '0;
            clean_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            idx_q   <= idx_d;
            clean_q <= clean_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        idx_d   = idx_q;
        clean_d = clean_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    mode_d  = cmd_inv;
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (hit) begin
                    idx_d   = hit_idx;
                    state_d = ST_WB;
                end else begin
                    clean_d = 1'b1;
                    state_d = mode_q ? ST_INVAL : ST_DONE;
                end
            end
            ST_WB: begin
                if (wb_ack) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                clean_d = !hit;
                state_d = (!hit && mode_q) ? ST_INVAL : ST_DONE;
            end
            ST_INVAL: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        wb_req    = (state_q == ST_WB);
        clr_en    = (state_q == ST_WB) && wb_ack;
        inv_en    = (state_q == ST_INVAL);
        done      = (state_q == ST_DONE);
    end

    assign wb_idx     = idx_q;
    assign inval      = {N_LINES{inv_en}};
    assign result     = pack_status(clean_q);
    assign flag_clean = clean_q;

endmodule

// File: rtl/dcl_clean_engine_chk.sv
module dcl_clean_engine_chk #(
    parameter int N_LINES = 16,
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_inv,
    input logic               cmd_ready,
    input logic [N_LINES-1:0] line_valid,
    input logic [N_LINES-1:0] line_dirty,
    input logic               wb_req,
    input logic [IDX_W-1:0]   wb_idx,
    input logic               wb_ack,
    input logic [N_LINES-1:0] dirty_clr,
    input logic [N_LINES-1:0] inval,
    input logic               done,
    input logic [31:0]        result,
    input logic               flag_clean
);
    logic mode_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      mode_seen <= 1'b0;
        else if (cmd_valid && cmd_ready) mode_seen <= cmd_inv;
    end

    // R4
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_idx));

    // R4
    clr_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dirty_clr) |-> wb_req && wb_ack && $onehot(dirty_clr) && dirty_clr[wb_idx]);

    // R3
    wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |-> line_valid[wb_idx] && line_dirty[wb_idx]);

    // R7
    inval_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inval) |-> (&inval) && ((line_valid & line_dirty) == '0));

    // R8
    inval_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inval) |-> mode_seen);

    // R5
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result[30] == ((line_valid & line_dirty) == '0)
                 && (result & ~(32'd1 << 30)) == 32'd0);

    // R6
    flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flag_clean == result[30]);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && cmd_ready);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req || done || (|inval)) |-> !cmd_ready);

endmodule

bind dcl_clean_engine dcl_clean_engine_chk #(.N_LINES(N_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_inv    (cmd_inv),
    .cmd_ready  (cmd_ready),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .wb_req     (wb_req),
    .wb_idx     (wb_idx),
    .wb_ack     (wb_ack),
    .dirty_clr  (dirty_clr),
    .inval      (inval),
    .done       (done),
    .result     (result),
    .flag_clean (flag_clean)
);

// File: tb/dcl_clean_engine_tb.sv
`timescale 1ns/1ps
module dcl_clean_engine_tb;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_inv = 1'b0;
    logic          cmd_ready;
    logic [N-1:0]  valid_m = '0;
    logic [N-1:0]  dirty_m = '0;
    logic          wb_req;
    logic [IW-1:0] wb_idx;
    logic          wb_ack = 1'b0;
    logic [N-1:0]  dirty_clr;
    logic [N-1:0]  inval;
    logic          done;
    logic [31:0]   result;
    logic          flag_clean;

    int vectors = 0;
    int fails   = 0;

    always #4 clk = ~clk;

    dcl_clean_engine #(.N_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_inv(cmd_inv),
        .cmd_ready(cmd_ready), .line_valid(valid_m), .line_dirty(dirty_m),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack), .dirty_clr(dirty_clr),
        .inval(inval), .done(done), .result(result), .flag_clean(flag_clean)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic do_cmd(input logic inv, input int lat, input logic poke,
                          output logic got_wb, output int wb_i,
                          output logic bit30, output logic saw_inv);
        int   wait_n;
        logic acked;
        logic fin;
        got_wb = 0; wb_i = -1; bit30 = 0; saw_inv = 0;
        wait_n = 0; acked = 0; fin = 0;
        @(negedge clk); cmd_valid = 1'b1; cmd_inv = inv;
        @(negedge clk); cmd_valid = 1'b0; cmd_inv = 1'b0;
        for (int c = 0; c < 60 && !fin; c++) begin
            wb_ack = 1'b0;
            #1;
            if (wb_req) begin
                if (acked) chk(0, "R2 second writeback", 1, 0);
                if (!got_wb) begin
                    got_wb = 1; wb_i = int'(wb_idx);
                end else begin
                    chk(int'(wb_idx) == wb_i, "R4 index held", wb_idx, wb_i);
                end
                if (wait_n < lat) begin
                    chk(dirty_clr == '0, "R4 no clear before ack", dirty_clr, 0);
                    if (poke && wait_n == 0) begin
                        cmd_valid = 1'b1;
                        chk(cmd_ready == 1'b0, "R9 busy not ready", cmd_ready, 0);
                    end
                    wait_n++;
                end else begin
                    wb_ack = 1'b1; acked = 1;
                    #1;
                    chk(dirty_clr == (N'(1) << wb_i), "R4 clear on ack", dirty_clr, N'(1) << wb_i);
                    dirty_m[wb_i] = 1'b0;
                end
            end
            if (|inval) begin
                saw_inv = 1;
                chk(&inval, "R7 all lines invalidated", inval, {N{1'b1}});
                valid_m = '0;
            end
            if (done) begin
                bit30 = result[30];
                chk((result & ~(32'd1 << 30)) == 0, "R5 other result bits", result, 0);
                chk(flag_clean == result[30], "R6 flag mirrors bit 30", flag_clean, result[30]);
                fin = 1;
            end
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wb_ack = 1'b0;
        if (!fin) chk(0, "R10 command never finished", 0, 1);
        else chk(!done && cmd_ready, "R10 done one cycle then ready", {done, cmd_ready}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic got; int wi; logic b; logic si;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready && !wb_req && !done && inval == '0 && dirty_clr == '0
            && result == 0 && !flag_clean, "R1 reset state",
            {cmd_ready, wb_req, done, flag_clean}, 4'b1000);

        for (int p = 0; p < 256; p++) begin
            logic [N-1:0] v0, d0, rem, rem2;
            logic inv;
            int lat, cmds, exp_i;
            v0  = p[0] ? (N'(p * 29) | N'(8'h11)) : {N{1'b1}};
            d0  = N'(p);
            inv = (p % 3 == 0);
            lat = p % 4;
            valid_m = v0; dirty_m = d0;
            cmds = 0;
            forever begin
                rem = valid_m & dirty_m;
                exp_i = lowest(rem);
                rem2 = rem;
                if (exp_i >= 0) rem2[exp_i] = 1'b0;
                do_cmd(inv, lat, 1'b0, got, wi, b, si);
                cmds++;
                chk(got == (rem != 0), "R2 one writeback per command", got, rem != 0);
                if (got) chk(wi == exp_i, "R3 lowest valid dirty line", wi, exp_i);
                chk(b == (rem2 == 0), "R5 status after clean", b, rem2 == 0);
                if (inv) chk(si == (rem2 == 0), "R7 invalidate when clean", si, rem2 == 0);
                else     chk(si == 0, "R8 no invalidate in clean-only", si, 0);
                if (b || cmds > N + 1) break;
            end
            chk(dirty_m == (d0 & ~v0), "R3 invalid dirty lines untouched", dirty_m, d0 & ~v0);
            if (inv) chk(valid_m == '0, "R7 all invalid afterwards", valid_m, 0);
            else     chk(valid_m == v0, "R8 valid bits kept", valid_m, v0);
        end

        // R9: command pulse during a pending writeback is not taken
        valid_m = '1; dirty_m = 8'b0100_0100;
        do_cmd(1'b0, 3, 1'b1, got, wi, b, si);
        chk(wi == 2 && b == 0, "R9 first command result", {wi, b}, {32'd2, 1'b0});
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (wb_req || done) extra++;
            end
            chk(extra == 0, "R9 busy pulse ignored", extra, 0);
        end
        chk(dirty_m == 8'b0100_0000, "R9 only one line cleaned", dirty_m, 8'b0100_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule